// File: doc/BRIEF.md
# Pre-renormalizing pipelined binary arithmetic encoder

This block is the interval-arithmetic core of a context-adaptive binary arithmetic encoder. One bin can enter on each clock. It comes with a bypass flag, the 6-bit probability state of its context and that context's most-probable value. The block keeps the 9-bit coding range and the 10-bit low register. For each bin it reports the number of left shifts applied to low and the full shifted low value, carry included. A downstream bit generator uses these to emit bits and settle outstanding bits. Context selection and update happen upstream, and bit packing happens downstream.

The work is split over three registered stages. The range recursion does not depend on low, so it runs one stage ahead of the low recursion. Stage 1 uses only the probability state. It looks up the LPS sub-range for all four range quarters. For each candidate it also finds the shift count needed to renormalize it and produces the shifted value. Stage 2 holds the range register. It picks one of the four prepared candidates using range bits [7:6], forms the MPS sub-range with its one-step renormalization, and commits the new range. Stage 3 holds the low register and applies one of the regular or bypass update rules through a single shared datapath. Bypass bins pass through the same three stages and leave the range untouched.

Top module: `bae_prenorm_encoder`

## Requirements
- R1: While `rst_n` is low and after its release, until the first bin leaves the pipe, `out_valid` is 0, `out_range` is 510 and `out_low` is 0. The internal range starts at 510 and the internal low starts at 0.
- R2: A bin sampled with `in_valid` high at a rising edge appears with `out_valid` high after the third rising edge that follows. Bins sampled on consecutive edges leave on consecutive cycles, in order.
- R3: For a regular bin, the LPS sub-range is the entry of the 64x4 standard LPS table at row `in_state` and column q = range[7:6], where range is the value left by the previous bin. States 0..62 are legal for regular bins.
- R4: For a regular LPS bin (`in_bin` != `in_mps`), the shift count is 6, 5, 4, 3, 2 or 1 when LPS sub-range bits [7:3] are 0, 1, 2..3, 4..7, 8..15 or 16..31. The new range is the LPS sub-range shifted left by that count.
- R5: For a regular MPS bin (`in_bin` == `in_mps`), rMPS = range - rLPS. If rMPS < 256 the new range is rMPS*2 and the shift is 1. Otherwise the new range is rMPS and the shift is 0.
- R6: A bypass bin (`in_bypass` = 1) reports a shift of 1 and leaves the range unchanged.
- R7: Low update rules. Regular MPS: `out_low` = low << shift. Regular LPS: `out_low` = (low + rMPS) << shift. Bypass 1: `out_low` = (low << 1) + range. Bypass 0: `out_low` = low << 1.
- R8: `out_low` is 17 bits wide and carries the whole untruncated result. The low register keeps only bits [9:0] of it for the next bin.
- R9: Cycles with `in_valid` low change neither the range nor the low. The outputs hold their last values while `out_valid` is 0.
- R10: A run of back-to-back regular bins that share one state is encoded at one bin per cycle, with no stall and the correct range chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A bin is offered this cycle |
| in_bypass | input | 1 | 1 = bypass (equiprobable) bin, 0 = regular bin |
| in_bin | input | 1 | Bin value |
| in_state | input | 6 | Probability state of the bin's context (regular bins) |
| in_mps | input | 1 | Most-probable value of the bin's context (regular bins) |
| out_valid | output | 1 | Outputs below belong to a newly encoded bin |
| out_bypass | output | 1 | The reported bin was a bypass bin |
| out_shift | output | 3 | Number of left shifts applied to low for this bin |
| out_range | output | 9 | Range after this bin |
| out_low | output | 17 | Untruncated new low, including carry and shifted-out bits |

## Verification
On every cycle the assertions check the three-cycle output timing and that every reported range is normalized. They also check that regular shift counts stay within six, that bypass bins keep the range and shift low by exactly one step, and that the outputs stay frozen between bins. Only the bench's scenarios show that the chosen LPS sub-range, the count table, the MPS rule and the low arithmetic agree bit for bit with a plain loop-based reference encoder. Those scenarios cover table rows, quarter selection, LPS-heavy runs, long same-state runs and random mixes with idle gaps.

// File: rtl/bae_pkg.sv
package bae_pkg;

    localparam int RANGE_W   = 9;
    localparam int LOW_W     = 10;
    localparam int STATE_W   = 6;
    localparam int NUM_Q     = 4;
    localparam int RLPS_W    = 8;
    localparam int MAX_SHIFT = 6;
    localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);
    localparam int WIDE_W    = LOW_W + 1 + MAX_SHIFT;
    localparam int NUM_STATE = 1 << STATE_W;
    localparam int ROW_W     = NUM_Q * RLPS_W;
    localparam int IDX_W     = RLPS_W - 3;
    localparam logic [RANGE_W-1:0] RANGE_INIT = RANGE_W'(510);

    // LPS sub-range per state, packed {q0, q1, q2, q3}
    localparam logic [ROW_W-1:0] RLPS_ROW [NUM_STATE] = '{
        {8'd128, 8'd176, 8'd208, 8'd240}, {8'd128, 8'd167, 8'd197, 8'd227},
        {8'd128, 8'd158, 8'd187, 8'd216}, {8'd123, 8'd150, 8'd178, 8'd205},
        {8'd116, 8'd142, 8'd169, 8'd195}, {8'd111, 8'd135, 8'd160, 8'd185},
        {8'd105, 8'd128, 8'd152, 8'd175}, {8'd100, 8'd122, 8'd144, 8'd166},
        {8'd95,  8'd116, 8'd137, 8'd158}, {8'd90,  8'd110, 8'd130, 8'd150},
        {8'd85,  8'd104, 8'd123, 8'd142}, {8'd81,  8'd99,  8'd117, 8'd135},
        {8'd77,  8'd94,  8'd111, 8'd128}, {8'd73,  8'd89,  8'd105, 8'd122},
        {8'd69,  8'd85,  8'd100, 8'd116}, {8'd66,  8'd80,  8'd95,  8'd110},
        {8'd62,  8'd76,  8'd90,  8'd104}, {8'd59,  8'd72,  8'd86,  8'd99},
        {8'd56,  8'd69,  8'd81,  8'd94},  {8'd53,  8'd65,  8'd77,  8'd89},
        {8'd51,  8'd62,  8'd73,  8'd85},  {8'd48,  8'd59,  8'd69,  8'd80},
        {8'd46,  8'd56,  8'd66,  8'd76},  {8'd43,  8'd53,  8'd63,  8'd72},
        {8'd41,  8'd50,  8'd59,  8'd69},  {8'd39,  8'd48,  8'd56,  8'd65},
        {8'd37,  8'd45,  8'd54,  8'd62},  {8'd35,  8'd43,  8'd51,  8'd59},
        {8'd33,  8'd41,  8'd48,  8'd56},  {8'd32,  8'd39,  8'd46,  8'd53},
        {8'd30,  8'd37,  8'd43,  8'd50},  {8'd29,  8'd35,  8'd41,  8'd48},
        {8'd27,  8'd33,  8'd39,  8'd45},  {8'd26,  8'd31,  8'd37,  8'd43},
        {8'd24,  8'd30,  8'd35,  8'd41},  {8'd23,  8'd28,  8'd33,  8'd39},
        {8'd22,  8'd27,  8'd32,  8'd37},  {8'd21,  8'd26,  8'd30,  8'd35},
        {8'd20,  8'd24,  8'd29,  8'd33},  {8'd19,  8'd23,  8'd27,  8'd31},
        {8'd18,  8'd22,  8'd26,  8'd30},  {8'd17,  8'd21,  8'd25,  8'd28},
        {8'd16,  8'd20,  8'd23,  8'd27},  {8'd15,  8'd19,  8'd22,  8'd25},
        {8'd14,  8'd18,  8'd21,  8'd24},  {8'd14,  8'd17,  8'd20,  8'd23},
        {8'd13,  8'd16,  8'd19,  8'd22},  {8'd12,  8'd15,  8'd18,  8'd21},
        {8'd12,  8'd14,  8'd17,  8'd20},  {8'd11,  8'd14,  8'd16,  8'd19},
        {8'd11,  8'd13,  8'd15,  8'd18},  {8'd10,  8'd12,  8'd15,  8'd17},
        {8'd10,  8'd12,  8'd14,  8'd16},  {8'd9,   8'd11,  8'd13,  8'd15},
        {8'd9,   8'd11,  8'd12,  8'd14},  {8'd8,   8'd10,  8'd12,  8'd14},
        {8'd8,   8'd9,   8'd11,  8'd13},  {8'd7,   8'd9,   8'd11,  8'd12},
        {8'd7,   8'd9,   8'd10,  8'd12},  {8'd7,   8'd8,   8'd10,  8'd11},
        {8'd6,   8'd8,   8'd9,   8'd11},  {8'd6,   8'd7,   8'd9,   8'd10},
        {8'd6,   8'd7,   8'd8,   8'd9},   {8'd2,   8'd2,   8'd2,   8'd2}
    };

    function automatic logic [RLPS_W-1:0] rlps_lookup(
        input logic [STATE_W-1:0] st,
        input logic [1:0]         q
    );
        logic [ROW_W-1:0] row;
        row = RLPS_ROW[st];
        return row[ROW_W - 1 - RLPS_W * int'(q) -: RLPS_W];
    endfunction

    // R4: shift count from the top five bits of the LPS sub-range
    function automatic logic [SHIFT_W-1:0] lps_shift_count(
        input logic [RLPS_W-1:0] rlps
    );
        logic [IDX_W-1:0] idx;
        idx = rlps[RLPS_W-1:3];
        if (idx[4])      return SHIFT_W'(1);
        else if (idx[3]) return SHIFT_W'(2);
        else if (idx[2]) return SHIFT_W'(3);
        else if (idx[1]) return SHIFT_W'(4);
        else if (idx[0]) return SHIFT_W'(5);
        else             return SHIFT_W'(6);
    endfunction

    typedef struct packed {
        logic                                 valid;
        logic                                 bypass;
        logic                                 lps;
        logic                                 bin;
        logic [NUM_Q-1:0][RLPS_W-1:0]         rlps;
        logic [NUM_Q-1:0][RANGE_W-1:0]        norm;
        logic [NUM_Q-1:0][SHIFT_W-1:0]        cnt;
    } s1_t;

    typedef struct packed {
        logic                 valid;
        logic                 bypass;
        logic [RANGE_W-1:0]   add;
        logic [SHIFT_W-1:0]   shift;
        logic [RANGE_W-1:0]   range_new;
    } s2_t;

endpackage

// File: rtl/bae_lps_precompute.sv
module bae_lps_precompute
    import bae_pkg::*;
(
    input  logic [STATE_W-1:0]             state,
    output logic [NUM_Q-1:0][RLPS_W-1:0]   rlps,
    output logic [NUM_Q-1:0][RANGE_W-1:0]  norm,
    output logic [NUM_Q-1:0][SHIFT_W-1:0]  cnt
);

    // R3/R4: every quarter candidate is prepared before the range is known
    for (genvar q = 0; q < NUM_Q; q++) begin : g_cand
        logic [RLPS_W-1:0]  sub;
        logic [SHIFT_W-1:0] sh;
        assign sub     = rlps_lookup(state, 2'(q));
        assign sh      = lps_shift_count(sub);
        assign rlps[q] = sub;
        assign cnt[q]  = sh;
        assign norm[q] = RANGE_W'({1'b0, sub} << sh);
    end

endmodule

// File: rtl/bae_range_stage.sv
module bae_range_stage
    import bae_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  s1_t  s1,
    output s2_t  s2
);

    logic [RANGE_W-1:0] range_q;
    logic [1:0]         quarter;
    logic [RANGE_W-1:0] rlps_sel;
    logic [RANGE_W-1:0] rmps;
    s2_t                nxt;

    assign quarter  = range_q[7:6];
    assign rlps_sel = RANGE_W'(s1.rlps[quarter]);
    assign rmps     = range_q - rlps_sel;

    always_comb begin
        nxt        = '0;
        nxt.valid  = s1.valid;
        nxt.bypass = s1.bypass;
        if (s1.bypass) begin
            // R6: range kept, one shift of low
            nxt.range_new = range_q;
            nxt.shift     = SHIFT_W'(1);
            nxt.add       = s1.bin ? range_q : '0;
        end else if (s1.lps) begin
            // R4: pre-shifted candidate, mux only
            nxt.range_new = s1.norm[quarter];
            nxt.shift     = s1.cnt[quarter];
            nxt.add       = rmps;
        end else if (rmps[RANGE_W-1]) begin
            // R5: MPS already normalized
            nxt.range_new = rmps;
            nxt.shift     = '0;
            nxt.add       = '0;
        end else begin
            nxt.range_new = {rmps[RANGE_W-2:0], 1'b0};
            nxt.shift     = SHIFT_W'(1);
            nxt.add       = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_q <= RANGE_INIT;
            s2      <= '0;
        end else begin
            s2 <= nxt;
            if (s1.valid) begin
                range_q <= nxt.range_new;   // R9: held on idle cycles
            end
        end
    end

endmodule

// File: rtl/bae_low_stage.sv
module bae_low_stage
    import bae_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  s2_t                 s2,
    output logic                out_valid,
    output logic                out_bypass,
    output logic [SHIFT_W-1:0]  out_shift,
    output logic [RANGE_W-1:0]  out_range,
    output logic [WIDE_W-1:0]   out_low
);

    logic [LOW_W-1:0]  low_q;
    logic [WIDE_W-1:0] base;
    logic [WIDE_W-1:0] addend;
    logic [WIDE_W-1:0] wide;

    assign base   = WIDE_W'(low_q);
    assign addend = WIDE_W'(s2.add);

    // R7: one datapath for regular and bypass bins
    always_comb begin
        if (s2.bypass) begin
            wide = (base << 1) + addend;
        end else begin
            wide = (base + addend) << s2.shift;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q      <= '0;
            out_valid  <= 1'b0;
            out_bypass <= 1'b0;
            out_shift  <= '0;
            out_range  <= RANGE_INIT;
            out_low    <= '0;
        end else begin
            out_valid <= s2.valid;
            if (s2.valid) begin
                low_q      <= wide[LOW_W-1:0];   // R8
                out_low    <= wide;
                out_shift  <= s2.shift;
                out_range  <= s2.range_new;
                out_bypass <= s2.bypass;
            end
        end
    end

endmodule

// File: rtl/bae_prenorm_encoder.sv
module bae_prenorm_encoder
    import bae_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_bypass,
    input  logic                  in_bin,
    input  logic [STATE_W-1:0]    in_state,
    input  logic                  in_mps,
    output logic                  out_valid,
    output logic                  out_bypass,
    output logic [SHIFT_W-1:0]    out_shift,
    output logic [RANGE_W-1:0]    out_range,
    output logic [WIDE_W-1:0]     out_low
);

    logic [NUM_Q-1:0][RLPS_W-1:0]  c_rlps;
    logic [NUM_Q-1:0][RANGE_W-1:0] c_norm;
    logic [NUM_Q-1:0][SHIFT_W-1:0] c_cnt;
    s1_t                           s1_q;
    s2_t                           s2_q;

    bae_lps_precompute u_pre (
        .state (in_state),
        .rlps  (c_rlps),
        .norm  (c_norm),
        .cnt   (c_cnt)
    );

    // Stage 1 register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
        end else begin
            s1_q.valid  <= in_valid;
            s1_q.bypass <= in_bypass;
            s1_q.lps    <= (in_bin != in_mps);
            s1_q.bin    <= in_bin;
            s1_q.rlps   <= c_rlps;
            s1_q.norm   <= c_norm;
            s1_q.cnt    <= c_cnt;
        end
    end

    bae_range_stage u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .s1    (s1_q),
        .s2    (s2_q)
    );

    bae_low_stage u_low (
        .clk        (clk),
        .rst_n      (rst_n),
        .s2         (s2_q),
        .out_valid  (out_valid),
        .out_bypass (out_bypass),
        .out_shift  (out_shift),
        .out_range  (out_range),
        .out_low    (out_low)
    );

endmodule

// File: rtl/bae_prenorm_checker.sv
module bae_prenorm_checker
    import bae_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_bypass,
    input  logic                  in_bin,
    input  logic [STATE_W-1:0]    in_state,
    input  logic                  in_mps,
    input  logic                  out_valid,
    input  logic                  out_bypass,
    input  logic [SHIFT_W-1:0]    out_shift,
    input  logic [RANGE_W-1:0]    out_range,
    input  logic [WIDE_W-1:0]     out_low
);

    logic [2:0]         vpipe;
    logic [RANGE_W-1:0] last_range;
    logic [LOW_W-1:0]   last_low;
    logic [WIDE_W-1:0]  byp_zero;
    logic [WIDE_W-1:0]  byp_one;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpipe      <= '0;
            last_range <= RANGE_INIT;
            last_low   <= '0;
        end else begin
            vpipe <= {vpipe[1:0], in_valid};
            if (out_valid) begin
                last_range <= out_range;
                last_low   <= out_low[LOW_W-1:0];
            end
        end
    end

    assign byp_zero = WIDE_W'({last_low, 1'b0});
    assign byp_one  = byp_zero + WIDE_W'(last_range);

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vpipe[2]); // R2

    AST_RANGE_NORM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_range[RANGE_W-1]); // R3

    AST_SHIFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_bypass) |-> (out_shift <= SHIFT_W'(MAX_SHIFT))); // R4

    AST_BYPASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bypass) |-> (out_range == last_range && out_shift == SHIFT_W'(1))); // R6

    AST_BYPASS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bypass) |-> (out_low == byp_zero || out_low == byp_one)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_range) && $stable(out_low))); // R9

endmodule

bind bae_prenorm_encoder bae_prenorm_checker u_chk (.*);

// File: tb/sim_bae_prenorm_encoder.sv
module sim_bae_prenorm_encoder;
    import bae_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int QD         = 8192;
    localparam int NVEC       = 16;
    localparam int NRAND      = 2500;

    // {bypass, bin, mps, state[5:0]}
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 6'd0},  {1'b0, 1'b1, 1'b0, 6'd0},
        {1'b0, 1'b1, 1'b0, 6'd62}, {1'b0, 1'b0, 1'b1, 6'd62},
        {1'b1, 1'b1, 1'b0, 6'd0},  {1'b1, 1'b0, 1'b0, 6'd0},
        {1'b0, 1'b1, 1'b1, 6'd30}, {1'b0, 1'b0, 1'b1, 6'd12},
        {1'b0, 1'b1, 1'b0, 6'd45}, {1'b1, 1'b1, 1'b1, 6'd5},
        {1'b0, 1'b0, 1'b0, 6'd20}, {1'b0, 1'b1, 1'b0, 6'd1},
        {1'b1, 1'b0, 1'b1, 6'd9},  {1'b0, 1'b0, 1'b1, 6'd58},
        {1'b0, 1'b1, 1'b1, 6'd3},  {1'b1, 1'b1, 1'b0, 6'd63}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_bypass = 1'b0;
    logic                in_bin = 1'b0;
    logic [STATE_W-1:0]  in_state = '0;
    logic                in_mps = 1'b0;
    logic                out_valid;
    logic                out_bypass;
    logic [SHIFT_W-1:0]  out_shift;
    logic [RANGE_W-1:0]  out_range;
    logic [WIDE_W-1:0]   out_low;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int wr      = 0;
    int rd      = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    int ref_range = 510;
    int ref_low   = 0;

    int exp_range [QD];
    int exp_low   [QD];
    int exp_shift [QD];
    int exp_cyc   [QD];
    int exp_kind  [QD];   // 0 MPS, 1 LPS, 2 bypass, 3 same-state run

    bae_prenorm_encoder u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_bypass  (in_bypass),
        .in_bin     (in_bin),
        .in_state   (in_state),
        .in_mps     (in_mps),
        .out_valid  (out_valid),
        .out_bypass (out_bypass),
        .out_shift  (out_shift),
        .out_range  (out_range),
        .out_low    (out_low)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    // Loop-based reference: one doubling per step until normalized
    task automatic send(input bit byp, input bit bin, input bit mps,
                        input logic [5:0] st, input int kind);
        int r, w, sh, lp, m;
        @(negedge clk);
        in_valid  = 1'b1;
        in_bypass = byp;
        in_bin    = bin;
        in_mps    = mps;
        in_state  = st;
        if (byp) begin
            r  = ref_range;
            w  = (ref_low << 1) + (bin ? ref_range : 0);
            sh = 1;
        end else begin
            lp = int'(rlps_lookup(st, 2'((ref_range >> 6) & 3)));
            m  = ref_range - lp;
            if (bin != mps) begin
                r = lp;
                w = ref_low + m;
            end else begin
                r = m;
                w = ref_low;
            end
            sh = 0;
            while (r < 256) begin
                r  = r << 1;
                w  = w << 1;
                sh = sh + 1;
            end
        end
        ref_range     = r;
        ref_low       = w & 1023;
        exp_range[wr] = r;
        exp_low[wr]   = w & ((1 << WIDE_W) - 1);
        exp_shift[wr] = sh;
        exp_cyc[wr]   = cyc;
        exp_kind[wr]  = byp ? 2 : kind;
        wr++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Output collector
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rd >= wr) begin
                check(1'b0, "R2 unexpected output", 1, 0);
            end else begin
                string tr;
                case (exp_kind[rd])
                    0: tr = "R5 MPS";
                    1: tr = "R4 LPS";
                    2: tr = "R6 bypass";
                    default: tr = "R10 same-state run";
                endcase
                check(cyc - exp_cyc[rd] == 3, "R2 latency", cyc - exp_cyc[rd], 3);
                check(int'(out_range) == exp_range[rd], {tr, " R3 range"},
                      int'(out_range), exp_range[rd]);
                check(int'(out_shift) == exp_shift[rd], {tr, " shift"},
                      int'(out_shift), exp_shift[rd]);
                check(int'(out_low) == exp_low[rd], {tr, " R7 R8 low"},
                      int'(out_low), exp_low[rd]);
                check(out_bypass == (exp_kind[rd] == 2), "R6 bypass flag",
                      int'(out_bypass), int'(exp_kind[rd] == 2));
                rd++;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", rd, wr);
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        check(out_range == 9'd510, "R1 range in reset", int'(out_range), 510);
        check(out_low == '0, "R1 low in reset", int'(out_low), 0);
        rst_n = 1'b1;
        idle(3);
        check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        check(out_range == 9'd510, "R1 range after reset", int'(out_range), 510);

        // Vector table, back to back
        for (int i = 0; i < NVEC; i++) begin
            logic [8:0] v;
            v = VEC[i];
            send(v[8], v[7], v[6], v[5:0], (v[7] != v[6]) ? 1 : 0);
        end
        idle(2);

        // R10: long run with one state, mixed MPS/LPS, no gaps
        for (int i = 0; i < 12; i++) begin
            send(1'b0, (i % 3 == 2), 1'b0, 6'd7, 3);
        end
        // R4: LPS-heavy run on the smallest sub-ranges (deep shifts)
        for (int i = 0; i < 8; i++) begin
            send(1'b0, 1'b1, 1'b0, 6'd62 - 6'(i), 1);
        end
        idle(5);

        // R9: idle cycles keep range and low
        check(out_valid == 1'b0, "R9 idle valid", int'(out_valid), 0);
        check(int'(out_range) == ref_range, "R9 range held", int'(out_range), ref_range);
        check(int'(out_low[LOW_W-1:0]) == ref_low, "R9 low held",
              int'(out_low[LOW_W-1:0]), ref_low);

        // Random mix of regular and bypass bins with gaps
        for (int i = 0; i < NRAND; i++) begin
            logic [31:0] rv;
            rv = next_rand();
            if (rv[3:0] == 4'd0) begin
                idle(1 + int'(rv[5:4]));
            end
            send(rv[8:6] < 3'd3, rv[9] ^ rv[10] ^ rv[11], rv[9],
                 6'(rv[27:20] % 63), (rv[9] != (rv[9] ^ rv[10] ^ rv[11])) ? 1 : 0);
        end
        idle(6);
        check(rd == wr, "R2 all bins delivered", rd, wr);
        check(int'(out_range) == ref_range, "R9 final range held", int'(out_range), ref_range);

        // R1: reset again restores initial values
        rst_n = 1'b0;
        idle(2);
        check(out_range == 9'd510, "R1 range after re-reset", int'(out_range), 510);
        check(out_low == '0, "R1 low after re-reset", int'(out_low), 0);
        check(out_valid == 1'b0, "R1 valid after re-reset", int'(out_valid), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule